// File: doc/BRIEF.md
# Mispredicted-Return Chain Scorer

This block watches the retired-instruction packets of a processor and keeps a score of how often mispredicted indirect jumps follow each other closely. A run of short code fragments, each ending in an indirect jump the predictor got wrong, is typical of return-oriented code reuse. Each such jump after a short stretch of code raises the score by one. Each such jump after a long stretch lowers it by two. A sticky alarm rises once the score reaches a fixed threshold.

Two scoring modes exist. Length mode measures the number of instructions retired since the previous mispredicted indirect jump. Packet mode only asks whether the previous valid packet also held a mispredict. Scoring runs only while monitoring is enabled. A clear pulse resets the score, the recorded maximum, the alarm and the mode history. The mispredict flag and the per-packet retired count come from the core's existing predictor and retire logic.

Top module: `rop_chain_scorer`

## Requirements
- R1: In length mode (`mode_sel`=0), a scoring packet has `pkt_valid`, `pkt_mispredict` and `monitor_en` all high. Its chain length is the sum of `pkt_retired` over the monitored valid packets since the last scoring packet (or since the last clear), including its own count. A length of SHORT_LEN (default 6) or less adds 1 to the score, and the length sum then restarts at zero.
- R2: In length mode, a scoring packet with a length above SHORT_LEN subtracts 2 from the score.
- R3: `alarm` rises in the same cycle the score first reaches ALARM_TH (default 10). It then stays high, even if the score falls, until a clear.
- R4: In packet mode (`mode_sel`=1), a scoring packet adds 1 if the most recent earlier monitored valid packet held a mispredict, and subtracts 2 otherwise. Packets with `pkt_valid` low do not change that history.
- R5: While `monitor_en` is low, the score does not change. Packets with `pkt_valid` low never change the score.
- R6: `clear` zeroes `score`, `score_max`, `alarm` and both mode histories. It overrides any score update in the same cycle.
- R7: A subtraction never takes the score below zero. A score of 0 or 1 becomes 0.
- R8: The score saturates at its all-ones value (2^SCORE_W − 1) and does not wrap.
- R9: `score_max` equals the highest score reached since the last clear, and it updates in the same cycle as the score.
- R10: The score moves only at scoring packets, by +1 or −2, and the new value appears one clock after the packet is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Packet holds at least one retired instruction |
| pkt_mispredict | input | 1 | Packet holds a mispredicted indirect jump |
| pkt_retired | input | CNT_W | Instructions retired in the packet |
| monitor_en | input | 1 | Scoring enable |
| clear | input | 1 | Synchronous clear of score, maximum, alarm and history |
| mode_sel | input | 1 | 0 = length mode, 1 = packet mode |
| score | output | SCORE_W | Current chain score |
| score_max | output | SCORE_W | Highest score since last clear |
| alarm | output | 1 | Sticky threshold alarm |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses the default 32-bit score, so threshold, floor, sticky-alarm and mode behaviour are seen on a realistic width. The second uses a 4-bit score, which puts the all-ones ceiling of 15 within reach of a short run of short chains. That copy shows saturation against the 32-bit copy, which keeps counting. The length boundary is exercised with chains of exactly 6 and exactly 7 instructions, split across packets.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic {
        MODE_LENGTH = 1'b0,
        MODE_PACKET = 1'b1
    } score_mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } score_step_e;

endpackage

// File: rtl/rop_gap_tracker.sv
module rop_gap_tracker #(
    parameter int CNT_W     = 4,
    parameter int SHORT_LEN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             pkt_mispredict,
    input  logic [CNT_W-1:0] pkt_retired,
    output logic             is_short
);
    localparam int LIM   = SHORT_LEN + 1;
    localparam int GAP_W = $clog2(LIM + 1);
    localparam int SUM_W = ((GAP_W > CNT_W) ? GAP_W : CNT_W) + 1;
    localparam logic [SUM_W-1:0] LIM_V   = SUM_W'(LIM);
    localparam logic [GAP_W-1:0] SHORT_V = GAP_W'(SHORT_LEN);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
    } gap_state_t;

    gap_state_t       st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [GAP_W-1:0] len_sat;

    always_comb begin
        sum     = SUM_W'(st_q.gap) + SUM_W'(pkt_retired);
        len_sat = (sum > LIM_V) ? GAP_W'(LIM) : GAP_W'(sum);
        st_d    = st_q;
        if (clear) begin
            st_d.gap = '0;
        end else if (take) begin
            st_d.gap = pkt_mispredict ? '0 : len_sat;
        end
    end

    assign is_short = (len_sat <= SHORT_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rop_pkt_history.sv
module rop_pkt_history (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic take,
    input  logic pkt_mispredict,
    output logic prev_mp
);
    typedef struct packed {
        logic last_mp;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)      st_d.last_mp = 1'b0;
        else if (take)  st_d.last_mp = pkt_mispredict;
    end

    assign prev_mp = st_q.last_mp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rop_score_accum.sv
module rop_score_accum
    import rop_pkg::*;
#(
    parameter int SCORE_W  = 32,
    parameter int ALARM_TH = 10,
    parameter int DEC_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  score_step_e        step,
    output logic [SCORE_W-1:0] score,
    output logic [SCORE_W-1:0] score_max,
    output logic               alarm
);
    localparam logic [SCORE_W-1:0] TH_V   = SCORE_W'(ALARM_TH);
    localparam logic [SCORE_W-1:0] DEC_V  = SCORE_W'(DEC_STEP);
    localparam logic [SCORE_W-1:0] ONES_V = '1;

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic [SCORE_W-1:0] peak;
        logic               alarm;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            unique case (step)
                STEP_UP:   st_d.score = (st_q.score == ONES_V) ? st_q.score : st_q.score + 1'b1;
                STEP_DOWN: st_d.score = (st_q.score < DEC_V) ? '0 : st_q.score - DEC_V;
                default:   st_d.score = st_q.score;
            endcase
            if (st_d.score > st_q.peak) st_d.peak = st_d.score;
            if (st_d.score >= TH_V)     st_d.alarm = 1'b1;
        end
    end

    assign score     = st_q.score;
    assign score_max = st_q.peak;
    assign alarm     = st_q.alarm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rop_chain_scorer.sv
module rop_chain_scorer
    import rop_pkg::*;
#(
    parameter int SCORE_W   = 32,
    parameter int CNT_W     = 4,
    parameter int SHORT_LEN = 6,
    parameter int ALARM_TH  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic               pkt_mispredict,
    input  logic [CNT_W-1:0]   pkt_retired,
    input  logic               monitor_en,
    input  logic               clear,
    input  logic               mode_sel,
    output logic [SCORE_W-1:0] score,
    output logic [SCORE_W-1:0] score_max,
    output logic               alarm
);
    logic        take;
    logic        hit;
    logic        gap_short;
    logic        prev_mp;
    logic        chain_short;
    score_mode_e mode;
    score_step_e step_d;

    assign take = pkt_valid & monitor_en;
    assign hit  = take & pkt_mispredict;
    assign mode = score_mode_e'(mode_sel);

    rop_gap_tracker #(
        .CNT_W     (CNT_W),
        .SHORT_LEN (SHORT_LEN)
    ) u_gap (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clear),
        .take           (take),
        .pkt_mispredict (pkt_mispredict),
        .pkt_retired    (pkt_retired),
        .is_short       (gap_short)
    );

    rop_pkt_history u_hist (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clear),
        .take           (take),
        .pkt_mispredict (pkt_mispredict),
        .prev_mp        (prev_mp)
    );

    always_comb begin
        chain_short = (mode == MODE_PACKET) ? prev_mp : gap_short;
        step_d      = STEP_HOLD;
        if (hit) step_d = chain_short ? STEP_UP : STEP_DOWN;
    end

    rop_score_accum #(
        .SCORE_W  (SCORE_W),
        .ALARM_TH (ALARM_TH),
        .DEC_STEP (2)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .step      (step_d),
        .score     (score),
        .score_max (score_max),
        .alarm     (alarm)
    );
endmodule

// File: rtl/rop_chain_scorer_chk.sv
module rop_chain_scorer_chk #(
    parameter int SCORE_W  = 32,
    parameter int ALARM_TH = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic               pkt_mispredict,
    input logic               monitor_en,
    input logic               clear,
    input logic [SCORE_W-1:0] score,
    input logic [SCORE_W-1:0] score_max,
    input logic               alarm
);
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (score == '0 && score_max == '0 && !alarm));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(pkt_valid && monitor_en && pkt_mispredict)) |=> $stable(score));

    // R3
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clear) |=> alarm);

    // R3
    alarm_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (score_max >= SCORE_W'(ALARM_TH)));

    // R9
    peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_max >= score);

    // R10
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (score > $past(score)) |-> ({1'b0, score} == {1'b0, $past(score)} + 1'b1));
endmodule

bind rop_chain_scorer rop_chain_scorer_chk #(
    .SCORE_W  (SCORE_W),
    .ALARM_TH (ALARM_TH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_valid      (pkt_valid),
    .pkt_mispredict (pkt_mispredict),
    .monitor_en     (monitor_en),
    .clear          (clear),
    .score          (score),
    .score_max      (score_max),
    .alarm          (alarm)
);

// File: tb/tb_rop_chain_scorer.sv
`timescale 1ns/1ps
module tb_rop_chain_scorer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic        pkt_mispredict = 1'b0;
    logic [3:0]  pkt_retired = '0;
    logic        monitor_en = 1'b1;
    logic        clear = 1'b0;
    logic        mode_sel = 1'b0;
    logic [31:0] score, score_max;
    logic        alarm;
    logic [3:0]  s_score, s_max;
    logic        s_alarm;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rop_chain_scorer dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_mispredict(pkt_mispredict),
        .pkt_retired(pkt_retired), .monitor_en(monitor_en), .clear(clear), .mode_sel(mode_sel),
        .score(score), .score_max(score_max), .alarm(alarm));

    rop_chain_scorer #(.SCORE_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_mispredict(pkt_mispredict),
        .pkt_retired(pkt_retired), .monitor_en(monitor_en), .clear(clear), .mode_sel(mode_sel),
        .score(s_score), .score_max(s_max), .alarm(s_alarm));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one packet for one cycle, then return to idle and stop at a negedge.
    task automatic pkt(input logic v, input logic m, input int n);
        @(negedge clk);
        pkt_valid = v; pkt_mispredict = m; pkt_retired = 4'(n);
        @(negedge clk);
        pkt_valid = 1'b0; pkt_mispredict = 1'b0; pkt_retired = '0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset score", score, 0);
        chk("R6 reset max", score_max, 0);
        chk("R6 reset alarm", alarm, 0);
    endtask

    task automatic t_short_chain();
        mode_sel = 1'b0;
        for (int i = 0; i < 9; i++) pkt(1, 1, 3);
        chk("R1 short chain score", score, 9);
        chk("R3 alarm below threshold", alarm, 0);
        pkt(1, 1, 3);
        chk("R3 alarm at threshold", alarm, 1);
        chk("R9 max follows", score_max, 10);
    endtask

    task automatic t_long_and_edge();
        pkt(1, 0, 4);
        chk("R1 plain packet no change", score, 10);
        pkt(1, 1, 3);              // 4+3 = 7 > 6
        chk("R2 length 7 subtracts", score, 8);
        chk("R9 max kept", score_max, 10);
        chk("R3 alarm sticky", alarm, 1);
        pkt(1, 0, 2);
        pkt(1, 1, 4);              // 2+4 = 6
        chk("R1 length 6 adds", score, 9);
        pkt(1, 0, 15);
        pkt(1, 1, 1);              // saturated gap
        chk("R2 long gap after big packet", score, 7);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clear = 1'b1; pkt_valid = 1'b1; pkt_mispredict = 1'b1; pkt_retired = 4'd1;
        @(negedge clk);
        clear = 1'b0; pkt_valid = 1'b0; pkt_mispredict = 1'b0; pkt_retired = '0;
        chk("R6 clear score priority", score, 0);
        chk("R6 clear max", score_max, 0);
        chk("R6 clear alarm", alarm, 0);
    endtask

    task automatic t_floor();
        pkt(1, 1, 7);
        chk("R7 floor from 0", score, 0);
        pkt(1, 1, 2);
        chk("R1 after restart", score, 1);
        pkt(1, 1, 8);
        chk("R7 floor from 1", score, 0);
    endtask

    task automatic t_gate();
        pkt(1, 1, 1);
        chk("R5 baseline", score, 1);
        monitor_en = 1'b0;
        pkt(1, 1, 1);
        pkt(1, 1, 1);
        chk("R5 disabled no change", score, 1);
        monitor_en = 1'b1;
        pkt(0, 1, 1);
        chk("R5 invalid packet ignored", score, 1);
    endtask

    task automatic t_packet_mode();
        do_clear();
        mode_sel = 1'b1;
        pkt(1, 1, 1); pkt(1, 1, 1); pkt(1, 1, 1);
        chk("R4 consecutive mispredicts", score, 2);
        pkt(0, 0, 0);
        pkt(1, 1, 9);
        chk("R4 invalid keeps history", score, 3);
        pkt(1, 0, 1);
        pkt(1, 1, 1);
        chk("R4 plain predecessor subtracts", score, 1);
        mode_sel = 1'b0;
    endtask

    task automatic t_saturate();
        do_clear();
        for (int i = 0; i < 17; i++) pkt(1, 1, 1);
        chk("R8 wide keeps counting", score, 17);
        chk("R8 narrow saturates", s_score, 15);
        chk("R8 narrow max", s_max, 15);
        pkt(1, 1, 1);
        chk("R8 narrow holds at ceiling", s_score, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_chain();
        t_long_and_edge();
        t_clear();
        t_floor();
        t_gate();
        t_packet_mode();
        t_saturate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule